// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block runs the host side of Enhanced Parallel Port handshakes. A synchronous host side requests one cycle at a time: read or write, data or address. The engine then moves the parallel port pins through the interlocked handshake with the peripheral, whose wait line paces each phase. A ready output stands in for an ISA channel-ready line. It drops as soon as a cycle is accepted and rises again when the host side may finish. For reads, that moment is when the peripheral has presented valid data, and the byte is latched at the same time.

Between cycles the port acts as a standard parallel port. The data pins and the three legacy control outputs copy the host's control-register values, and the bus direction follows the direction control bit. The incoming wait line is resynchronised in a two-stage synchronizer. A watchdog counts clock cycles from acceptance of a request. When the count reaches 10 µs, derived from the clock-frequency parameter, it abandons the cycle and raises a sticky timeout flag that the host clears explicitly.

Top module: `epp_cycle_engine`

## Requirements
- R1: While idle, host_ready is 1, n_write, n_datastb and n_addrstb are 1, pd_out equals spp_data, ctl_strobe/ctl_autofd/ctl_init equal spp_strobe/spp_autofd/spp_init, pdir equals spp_pcd and pd_oe equals the inverse of spp_pcd (pdir 1 = input).
- R2: A req_valid pulse seen while idle starts a cycle and host_ready is 0 one clock later; a req_valid pulse while a cycle is still running is ignored and starts no cycle.
- R3: While the synchronised wait line is high after a request, n_write and both strobes stay at 1; the cycle advances only once n_wait has been low through the two-stage synchronizer.
- R4: In a write cycle, pd_out carries req_wdata, pd_oe is 1, pdir is 0 and n_write is 0 while the strobe is low; the strobe returns high once n_wait is seen high.
- R5: In a read cycle, pd_oe is 0, pdir is 1 and n_write is 1 while the strobe is low, and host_ready stays 0 until the peripheral's data is taken.
- R6: n_datastb goes low for a data cycle (req_addr = 0) and n_addrstb for an address cycle (req_addr = 1); both are never low together.
- R7: In a read, when n_wait is seen high, pd_in is copied to rd_data, rd_valid pulses for one clock, host_ready returns to 1 and the strobe returns to 1.
- R8: After the strobe is released, n_write, pdir, pd_oe and pd_out keep their cycle values until n_wait is seen low again; the port then returns to the idle behaviour of R1.
- R9: When a cycle has not ended CLK_HZ/100000 clocks after its acceptance, it is aborted: both strobes go high, the pins return to the idle behaviour of R1, host_ready is 1 and stat_timeout becomes 1; cycles that end in time leave stat_timeout unchanged.
- R10: stat_timeout is sticky; it clears on stat_clr, or on stat_wr with stat_wbit0 = 1, but not on stat_wr with stat_wbit0 = 0; if an abort and a clear fall in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-clock request pulse |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| req_wdata | input | DW | Byte to send in a write |
| rd_data | output | DW | Byte captured in the last read |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |
| host_ready | output | 1 | 0 holds the host cycle open |
| stat_wr | input | 1 | Status write strobe |
| stat_wbit0 | input | 1 | Bit 0 of status write data (1 clears) |
| stat_clr | input | 1 | Direct clear of the timeout flag |
| stat_timeout | output | 1 | Sticky timeout flag (status bit 0) |
| spp_data | input | DW | Standard-mode data register |
| spp_strobe | input | 1 | Standard-mode strobe control bit |
| spp_autofd | input | 1 | Standard-mode auto-feed control bit |
| spp_init | input | 1 | Standard-mode init control bit |
| spp_pcd | input | 1 | Standard-mode direction bit, 1 = input |
| n_wait | input | 1 | Peripheral wait line, asynchronous |
| pd_in | input | DW | Parallel data bus, received |
| pd_out | output | DW | Parallel data bus, driven |
| pd_oe | output | 1 | Data bus output enable |
| pdir | output | 1 | Bus direction, 1 = input |
| n_write | output | 1 | Active-low write indication |
| n_datastb | output | 1 | Active-low data strobe |
| n_addrstb | output | 1 | Active-low address strobe |
| ctl_strobe | output | 1 | Legacy strobe output |
| ctl_autofd | output | 1 | Legacy auto-feed output |
| ctl_init | output | 1 | Legacy init output |

## Verification
The watchdog abort and a host clear of the timeout flag can land in the same clock. The bench provokes this with a request whose wait line never falls. It counts clock edges from acceptance and pulses stat_clr so that it is sampled on the exact edge where the abort happens. Just before that edge the flag must read 0 and host_ready 0. Just after it, the flag must read 1 and host_ready 1, which shows the set taking priority over the clear.

// File: rtl/epp_pkg.sv
// Package: shared state encoding and timing helpers for the EPP engine.
// Assumes: the clock frequency parameter is a whole number of hertz.
package epp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // standard-port behaviour
        ST_WAITLO,  // request held, waiting for wait line low
        ST_SETUP,   // direction / nWRITE / data set up
        ST_STROBE,  // strobe low, waiting for wait line high
        ST_TERM     // strobe released, waiting for wait line low
    } epp_state_t;

    // Number of clocks in the 10 us watchdog window.
    function automatic int wd_cycles(input longint hz);
        return int'(hz / 100_000);
    endfunction

endpackage

// File: rtl/epp_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes: the input is a slow level; the reset value is the idle level.
module epp_sync #(
    parameter int    STAGES   = 2,
    parameter bit    RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/epp_watchdog.sv
// Module: cycle watchdog; counts clocks while a cycle runs, flags expiry.
// Assumes: run falls for at least one clock between cycles, which restarts the count.
module epp_watchdog #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count clocks of the running cycle; restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (run)  cnt <= cnt + 1'b1;
        else           cnt <= '0;
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));

    // An expiry must end the cycle on the next clock.
    assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run);
endmodule

// File: rtl/epp_cycle_engine.sv
// Module: host-side EPP cycle engine (top).
// Sequences one data or address cycle per request against the peripheral
// wait line, stands in for the standard port between cycles, and aborts
// cycles that exceed the watchdog window.
// Assumes: requests come only while host_ready is 1; n_wait is asynchronous.
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter longint CLK_HZ      = 125_000_000,
    parameter int     DW          = 8,
    parameter int     SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          host_ready,
    input  logic          stat_wr,
    input  logic          stat_wbit0,
    input  logic          stat_clr,
    output logic          stat_timeout,
    input  logic [DW-1:0] spp_data,
    input  logic          spp_strobe,
    input  logic          spp_autofd,
    input  logic          spp_init,
    input  logic          spp_pcd,
    input  logic          n_wait,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          pdir,
    output logic          n_write,
    output logic          n_datastb,
    output logic          n_addrstb,
    output logic          ctl_strobe,
    output logic          ctl_autofd,
    output logic          ctl_init
);
    localparam int WD_LIMIT = wd_cycles(CLK_HZ);

    epp_state_t    state;
    logic          wait_s;
    logic          abort;
    logic          cyc_wr;
    logic          cyc_addr;
    logic [DW-1:0] cyc_data;
    logic          bus_owned;
    logic          strb_on;

    epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (n_wait),
        .dout  (wait_s)
    );

    epp_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state != ST_IDLE),
        .expire (abort)
    );

    // Cycle sequencer: request capture, handshake phases and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cyc_wr   <= 1'b0;
            cyc_addr <= 1'b0;
            cyc_data <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (abort) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (req_valid) begin
                        cyc_wr   <= req_write;
                        cyc_addr <= req_addr;
                        cyc_data <= req_wdata;
                        state    <= ST_WAITLO;
                    end
                    ST_WAITLO: if (!wait_s) state <= ST_SETUP;
                    ST_SETUP:  state <= ST_STROBE;
                    ST_STROBE: if (wait_s) begin
                        if (!cyc_wr) begin
                            rd_data  <= pd_in;
                            rd_valid <= 1'b1;
                        end
                        state <= ST_TERM;
                    end
                    ST_TERM:   if (!wait_s) state <= ST_IDLE;
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

    // Sticky timeout flag; an abort outranks a clear in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   stat_timeout <= 1'b0;
        else if (abort)                               stat_timeout <= 1'b1;
        else if (stat_clr || (stat_wr && stat_wbit0)) stat_timeout <= 1'b0;
    end

    // Pin multiplexing between cycle-driven and standard-port values.
    always_comb begin
        bus_owned  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_TERM);
        strb_on    = (state == ST_STROBE);
        n_write    = !(bus_owned && cyc_wr);
        pd_oe      = bus_owned ? cyc_wr   : !spp_pcd;
        pdir       = bus_owned ? !cyc_wr  : spp_pcd;
        pd_out     = bus_owned ? cyc_data : spp_data;
        n_datastb  = !(strb_on && !cyc_addr);
        n_addrstb  = !(strb_on && cyc_addr);
        host_ready = (state == ST_IDLE) || (state == ST_TERM);
        ctl_strobe = (state == ST_IDLE) ? spp_strobe : 1'b1;
        ctl_autofd = (state == ST_IDLE) ? spp_autofd : 1'b1;
        ctl_init   = (state == ST_IDLE) ? spp_init   : 1'b1;
    end

    // Both strobes are never low together.
    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!n_datastb && !n_addrstb));

    // A strobe only starts after the synchronised wait line was seen low.
    assert_strobe_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(n_datastb && n_addrstb) |-> !$past(wait_s, 2));

    // During a read strobe the bus is released and the host is held.
    assert_read_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((!n_datastb || !n_addrstb) && n_write) |-> (!pd_oe && pdir && !host_ready));

    // During a write strobe the bus is driven.
    assert_write_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!n_datastb || !n_addrstb) && !n_write) |-> (pd_oe && !pdir));

    // The timeout flag only falls after a clear request.
    assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_timeout) |-> $past(stat_clr || (stat_wr && stat_wbit0)));
endmodule

// File: tb/epp_cycle_engine_tb.sv
module epp_cycle_engine_tb;
    localparam longint HZ       = 125_000_000;
    localparam int     TB_LIMIT = 1250;   // 10 us at 125 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 0, req_write = 0, req_addr = 0;
    logic [7:0] req_wdata = 0;
    logic [7:0] rd_data;
    logic       rd_valid, host_ready;
    logic       stat_wr = 0, stat_wbit0 = 0, stat_clr = 0;
    logic       stat_timeout;
    logic [7:0] spp_data = 8'h5A;
    logic       spp_strobe = 1, spp_autofd = 0, spp_init = 1, spp_pcd = 0;
    logic       n_wait = 1;
    logic [7:0] pd_in = 0;
    logic [7:0] pd_out;
    logic       pd_oe, pdir, n_write, n_datastb, n_addrstb;
    logic       ctl_strobe, ctl_autofd, ctl_init;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    epp_cycle_engine #(.CLK_HZ(HZ), .DW(8), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .host_ready(host_ready), .stat_wr(stat_wr),
        .stat_wbit0(stat_wbit0), .stat_clr(stat_clr), .stat_timeout(stat_timeout),
        .spp_data(spp_data), .spp_strobe(spp_strobe), .spp_autofd(spp_autofd),
        .spp_init(spp_init), .spp_pcd(spp_pcd), .n_wait(n_wait), .pd_in(pd_in),
        .pd_out(pd_out), .pd_oe(pd_oe), .pdir(pdir), .n_write(n_write),
        .n_datastb(n_datastb), .n_addrstb(n_addrstb), .ctl_strobe(ctl_strobe),
        .ctl_autofd(ctl_autofd), .ctl_init(ctl_init)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Idle pin image packed for comparison (R1).
    function automatic int idle_img();
        return {pd_out, pd_oe, pdir, n_write, n_datastb, n_addrstb, host_ready,
                ctl_strobe, ctl_autofd, ctl_init};
    endfunction
    function automatic int idle_exp();
        return {spp_data, !spp_pcd, spp_pcd, 1'b1, 1'b1, 1'b1, 1'b1,
                spp_strobe, spp_autofd, spp_init};
    endfunction

    // Monitor: pop expected read bytes as the design reports them (R7).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R7 unexpected rd_valid", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R7 read data", rd_data, e);
            end
        end
    end

    // Driver: one full handshake with a peripheral model.
    task automatic do_cycle(input bit wr, input bit adr, input logic [7:0] d,
                            input bit start_high, input bit inject);
        int n;
        n_wait = start_high;
        repeat (4) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = adr; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(host_ready == 0, "R2 ready low after accept", host_ready, 0);
        if (start_high) begin
            repeat (6) @(negedge clk);
            chk({n_write, n_datastb, n_addrstb} == 3'b111, "R3 held while wait high",
                {n_write, n_datastb, n_addrstb}, 7);
            n_wait = 0;
        end
        n = 0;
        while (n_datastb && n_addrstb && n < 50) begin @(negedge clk); n++; end
        chk({n_datastb, n_addrstb} == (adr ? 2'b10 : 2'b01), "R6 strobe select",
            {n_datastb, n_addrstb}, adr ? 2 : 1);
        if (wr) chk({pd_out, pd_oe, pdir, n_write} == {d, 3'b100}, "R4 write setup",
                    {pd_out, pd_oe, pdir, n_write}, {d, 3'b100});
        else    chk({pd_oe, pdir, n_write, host_ready} == 4'b0110, "R5 read setup",
                    {pd_oe, pdir, n_write, host_ready}, 6);
        if (!wr) begin pd_in = d; exp_q.push_back(d); end
        @(negedge clk);
        n_wait = 1;
        n = 0;
        while (!(n_datastb && n_addrstb) && n < 50) begin @(negedge clk); n++; end
        chk(n < 50 && host_ready == 1, wr ? "R4 strobe released" : "R7 ready released",
            host_ready, 1);
        if (inject) begin
            req_valid = 1; req_write = 1; req_wdata = 8'hEE;
            @(negedge clk);
            req_valid = 0;
        end
        repeat (3) @(negedge clk);
        chk({n_write, pdir, pd_oe} == {!wr, !wr, wr}, "R8 held until wait low",
            {n_write, pdir, pd_oe}, {!wr, !wr, wr});
        n_wait = 0;
        repeat (5) @(negedge clk);
        chk(idle_img() == idle_exp(), "R8 back to idle", idle_img(), idle_exp());
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(idle_img() == idle_exp(), "R1 reset idle", idle_img(), idle_exp());
        chk(stat_timeout == 0, "R10 reset flag", stat_timeout, 0);
        spp_data = 8'hC3; spp_pcd = 1; spp_strobe = 0; spp_init = 0; spp_autofd = 1;
        @(negedge clk);
        chk(idle_img() == idle_exp(), "R1 follows control reg", idle_img(), idle_exp());
        spp_pcd = 0;

        do_cycle(1, 0, 8'hA5, 1, 0);   // write data, wait starts high
        do_cycle(0, 0, 8'h3C, 0, 0);   // read data
        do_cycle(1, 1, 8'h81, 0, 0);   // write address
        do_cycle(0, 1, 8'h7E, 1, 0);   // read address, wait starts high
        do_cycle(1, 0, 8'h11, 0, 1);   // request injected mid-cycle
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!(host_ready && n_write))
                chk(0, "R2 injected request ignored", {host_ready, n_write}, 3);
        end
        chk(host_ready && n_write, "R2 injected request ignored", {host_ready, n_write}, 3);
        chk(stat_timeout == 0, "R9 no timeout on normal cycles", stat_timeout, 0);
        chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);

        // Abort and clear in the same clock (R9, R10).
        n_wait = 1;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        repeat (TB_LIMIT - 1) @(posedge clk);
        @(negedge clk);
        chk(stat_timeout == 0 && host_ready == 0, "R9 not aborted early",
            {stat_timeout, host_ready}, 0);
        stat_clr = 1;
        @(posedge clk);
        @(negedge clk);
        stat_clr = 0;
        chk(stat_timeout == 1, "R10 set wins over clear", stat_timeout, 1);
        chk(idle_img() == idle_exp(), "R9 abort releases pins", idle_img(), idle_exp());
        @(negedge clk);
        stat_wr = 1; stat_wbit0 = 0;
        @(negedge clk);
        stat_wr = 0;
        chk(stat_timeout == 1, "R10 write of 0 keeps flag", stat_timeout, 1);
        stat_clr = 1;
        @(negedge clk);
        stat_clr = 0;
        chk(stat_timeout == 0, "R10 clear strobe", stat_timeout, 0);

        // Abort while the read strobe is low (R9).
        n_wait = 0;
        repeat (4) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 1;
        @(negedge clk);
        req_valid = 0;
        repeat (10) @(negedge clk);
        chk(n_addrstb == 0, "R6 address strobe low", n_addrstb, 0);
        repeat (TB_LIMIT) @(negedge clk);
        chk(stat_timeout == 1, "R9 abort during strobe", stat_timeout, 1);
        chk(idle_img() == idle_exp(), "R9 pins idle after abort", idle_img(), idle_exp());
        stat_wr = 1; stat_wbit0 = 1;
        @(negedge clk);
        stat_wr = 0; stat_wbit0 = 0;
        chk(stat_timeout == 0, "R10 write one clears", stat_timeout, 0);
        chk(exp_q.size() == 0, "R7 no capture on abort", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule